// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block is the address and count engine of a data transfer controller running in block mode. Software loads a source address, a destination address, a block size, a block count, a transfer unit (byte, 16-bit or 32-bit) and a step mode for the side that is not the block area. A select bit decides which side is the block area. Each activation moves exactly one block. For every unit in the block, the engine issues a read at the source address and then a write at the destination address over a simple request/acknowledge memory port.

Inside a block, the block-area address climbs by one unit per transfer. At the end of the block it falls back to the address it held when the block began, and the in-block counter reloads from the size register. The opposite address moves by one unit per transfer under its own mode (up, down or held) and keeps its position from one block to the next. At the end of each block the engine presents, for one cycle, the values to be written back to the transfer descriptor. It also decrements the block counter. When that counter runs out, it raises an interrupt.

Data movement, bus arbitration and the choice of trigger belong to the surrounding controller. This block only produces addresses, counts, write-back values and the interrupt.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset, `busy`, `mem_req`, `irq` and `wb_valid` are low.
- R2: Each unit is one read request (`mem_we`=0) at the source address, followed by one write request (`mem_we`=1) at the destination address. Each request keeps `mem_req`, `mem_addr` and `mem_we` steady until the cycle in which `mem_ack` is high.
- R3: The block-area address steps up by the unit size for each unit of a block and starts every block from the address it had when loaded. Unit code 0 is 1 byte, code 1 is 2 bytes, and codes 2 and 3 are 4 bytes.
- R4: The non-block address changes by the unit size after each unit. Step mode 1 adds, mode 2 subtracts, and modes 0 and 3 hold it. The position carries over into the next block.
- R5: When `cfg_src_is_block` is 1 the source address is the block area. When it is 0 the destination address is the block area.
- R6: A size value of 1 to 255 gives that many units per block. A size value of 0 gives 256 units.
- R7: `wb_valid` is high for exactly one cycle, the cycle after the acknowledge of the block's last write. In that cycle the write-back values are: the block-area address equal to its loaded value; the non-block address after its last step; `wb_size` and `wb_unit_cnt` equal to the size register; and `wb_count` equal to the remaining block count minus one.
- R8: The write-back enable of the block-area address is always 1. The write-back enable of the non-block address is 0 when its step mode holds it.
- R9: A count of N (1 to 65,535) allows N blocks, and a count of 0 allows 65,536. `irq` rises after the block whose write-back count is 0 and stays high until the next accepted configuration load.
- R10: `busy` is high from the cycle after an accepted `start` through the write-back cycle. `start` is ignored while busy or while `irq` is high. `cfg_load` is ignored while busy.

Top module ports are listed in order below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load all configuration fields (idle only) |
| cfg_src_addr | input | ADDR_W | Initial source address |
| cfg_dst_addr | input | ADDR_W | Initial destination address |
| cfg_src_is_block | input | 1 | 1: source is block area; 0: destination is |
| cfg_unit | input | 2 | Unit code: 0 byte, 1 two bytes, 2/3 four bytes |
| cfg_move | input | 2 | Non-block step mode: 1 up, 2 down, 0/3 hold |
| cfg_size | input | SIZE_W | Units per block, 0 = 2^SIZE_W |
| cfg_count | input | CNT_W | Number of blocks, 0 = 2^CNT_W |
| start | input | 1 | Activation pulse for one block |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Request address |
| mem_ack | input | 1 | Request accepted |
| busy | output | 1 | Block in progress |
| irq | output | 1 | All blocks done |
| wb_valid | output | 1 | Write-back values valid this cycle |
| wb_src_addr | output | ADDR_W | Source address to write back |
| wb_src_en | output | 1 | Source address write-back enable |
| wb_dst_addr | output | ADDR_W | Destination address to write back |
| wb_dst_en | output | 1 | Destination address write-back enable |
| wb_size | output | SIZE_W | Size storage value to write back |
| wb_unit_cnt | output | SIZE_W | In-block counter value to write back |
| wb_count | output | CNT_W | Block count to write back |

## Verification
The engine is tried with each side as the block area and with every unit width. The non-block side is run upward, downward and held, so that a swapped select, a wrong step size or a wrong step sign each shows up in the request address stream. Consecutive blocks under one configuration show whether the block side snaps back while the other side carries on. A full 256-unit block with a zero count separates the wrap-to-maximum encodings from a literal zero. A start and a configuration load issued mid-block, and a start issued after the interrupt, show that the engine refuses activations and loads at the wrong time.

// File: rtl/blkxfer_pkg.sv
`timescale 1ns/1ps
package blkxfer_pkg;

   typedef enum logic [1:0] {
      MOVE_HOLD  = 2'd0,
      MOVE_UP    = 2'd1,
      MOVE_DOWN  = 2'd2,
      MOVE_HOLD3 = 2'd3
   } move_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_WBACK = 2'd3
   } seq_state_e;

   // byte distance of one transfer unit
   function automatic logic [2:0] unit_bytes(input logic [1:0] code);
      logic [2:0] b;
      case (code)
         2'd0:    b = 3'd1;
         2'd1:    b = 3'd2;
         default: b = 3'd4;
      endcase
      return b;
   endfunction

   function automatic logic move_active(input logic [1:0] code);
      return (code == MOVE_UP) || (code == MOVE_DOWN);
   endfunction

endpackage

// File: rtl/blkxfer_addr_lane.sv
`timescale 1ns/1ps
module blkxfer_addr_lane
   import blkxfer_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              is_block,
   input  logic [1:0]        move,
   input  logic [2:0]        step_bytes,
   input  logic              unit_done,
   input  logic              block_end,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [ADDR_W-1:0] wb_addr,
   output logic              wb_en
);

   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] next_addr;
   logic [ADDR_W-1:0] step_ext;

   assign step_ext = ADDR_W'(step_bytes);

   always_comb begin
      next_addr = cur_q;
      if (is_block) begin
         next_addr = cur_q + step_ext;
      end else begin
         case (move)
            MOVE_UP:   next_addr = cur_q + step_ext;
            MOVE_DOWN: next_addr = cur_q - step_ext;
            default:   next_addr = cur_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cur_q  <= '0;
      end else if (load) begin
         base_q <= load_addr;
         cur_q  <= load_addr;
      end else if (block_end) begin
         if (is_block) begin
            cur_q <= base_q;
         end else begin
            base_q <= cur_q;
         end
      end else if (unit_done) begin
         cur_q <= next_addr;
      end
   end

   assign cur_addr = cur_q;
   assign wb_addr  = is_block ? base_q : cur_q;
   assign wb_en    = is_block | move_active(move);

endmodule

// File: rtl/blkxfer_unit_ctr.sv
`timescale 1ns/1ps
module blkxfer_unit_ctr #(
   parameter int SIZE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [SIZE_W-1:0] size_in,
   input  logic              unit_done,
   input  logic              block_end,
   output logic [SIZE_W-1:0] size_stor,
   output logic              last_unit
);

   localparam logic [SIZE_W-1:0] ONE = SIZE_W'(1);

   logic [SIZE_W-1:0] stor_q;
   logic [SIZE_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stor_q <= '0;
         left_q <= '0;
      end else if (load) begin
         stor_q <= size_in;
         left_q <= size_in;
      end else if (block_end) begin
         left_q <= stor_q;
      end else if (unit_done) begin
         left_q <= left_q - ONE;
      end
   end

   // a stored zero counts through the full range before hitting one
   assign last_unit = (left_q == ONE);
   assign size_stor = stor_q;

endmodule

// File: rtl/blkxfer_blk_ctr.sv
`timescale 1ns/1ps
module blkxfer_blk_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] count_in,
   input  logic             block_end,
   output logic [CNT_W-1:0] remain_after,
   output logic             irq
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else if (load) begin
         cnt_q <= count_in;
         irq_q <= 1'b0;
      end else if (block_end) begin
         cnt_q <= cnt_q - ONE;
         if (cnt_q == ONE) begin
            irq_q <= 1'b1;
         end
      end
   end

   assign remain_after = cnt_q - ONE;
   assign irq          = irq_q;

endmodule

// File: rtl/blkxfer_seq.sv
`timescale 1ns/1ps
module blkxfer_seq
   import blkxfer_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_load,
   input  logic [ADDR_W-1:0] cfg_src_addr,
   input  logic [ADDR_W-1:0] cfg_dst_addr,
   input  logic              cfg_src_is_block,
   input  logic [1:0]        cfg_unit,
   input  logic [1:0]        cfg_move,
   input  logic [SIZE_W-1:0] cfg_size,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic              start,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   output logic              busy,
   output logic              irq,
   output logic              wb_valid,
   output logic [ADDR_W-1:0] wb_src_addr,
   output logic              wb_src_en,
   output logic [ADDR_W-1:0] wb_dst_addr,
   output logic              wb_dst_en,
   output logic [SIZE_W-1:0] wb_size,
   output logic [SIZE_W-1:0] wb_unit_cnt,
   output logic [CNT_W-1:0]  wb_count
);

   localparam int LANES    = 2;
   localparam int LANE_SRC = 0;
   localparam int LANE_DST = 1;

   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr_w
      $error("blkxfer_seq: ADDR_W must lie in 8..64");
   end
   if (SIZE_W < 1 || SIZE_W > 16) begin : g_bad_size_w
      $error("blkxfer_seq: SIZE_W must lie in 1..16");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
      $error("blkxfer_seq: CNT_W must lie in 1..32");
   end

   seq_state_e state_q, state_d;
   logic       sel_q;
   logic [1:0] unit_q;
   logic [1:0] move_q;
   logic       cfg_take;
   logic       go;
   logic       unit_done;
   logic       block_end;
   logic       last_unit;
   logic       irq_int;
   logic [2:0] step_bytes;

   logic [LANES-1:0][ADDR_W-1:0] lane_cur;
   logic [LANES-1:0][ADDR_W-1:0] lane_wb;
   logic [LANES-1:0][ADDR_W-1:0] lane_init;
   logic [LANES-1:0]             lane_blk;
   logic [LANES-1:0]             lane_en;

   assign cfg_take   = cfg_load && (state_q == ST_IDLE);
   assign go         = start && !cfg_load && (state_q == ST_IDLE) && !irq_int;
   assign unit_done  = (state_q == ST_WRITE) && mem_ack;
   assign block_end  = (state_q == ST_WBACK);
   assign step_bytes = unit_bytes(unit_q);

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (go) state_d = ST_READ;
         ST_READ:  if (mem_ack) state_d = ST_WRITE;
         ST_WRITE: if (mem_ack) state_d = last_unit ? ST_WBACK : ST_READ;
         ST_WBACK: state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b1;
         unit_q <= 2'd0;
         move_q <= 2'd0;
      end else if (cfg_take) begin
         sel_q  <= cfg_src_is_block;
         unit_q <= cfg_unit;
         move_q <= cfg_move;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i == LANE_SRC) begin : g_src
         assign lane_blk[i]  = sel_q;
         assign lane_init[i] = cfg_src_addr;
      end else begin : g_dst
         assign lane_blk[i]  = ~sel_q;
         assign lane_init[i] = cfg_dst_addr;
      end

      blkxfer_addr_lane #(.ADDR_W(ADDR_W)) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (cfg_take),
         .load_addr  (lane_init[i]),
         .is_block   (lane_blk[i]),
         .move       (move_q),
         .step_bytes (step_bytes),
         .unit_done  (unit_done),
         .block_end  (block_end),
         .cur_addr   (lane_cur[i]),
         .wb_addr    (lane_wb[i]),
         .wb_en      (lane_en[i])
      );
   end

   blkxfer_unit_ctr #(.SIZE_W(SIZE_W)) u_unit_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cfg_take),
      .size_in   (cfg_size),
      .unit_done (unit_done),
      .block_end (block_end),
      .size_stor (wb_size),
      .last_unit (last_unit)
   );

   blkxfer_blk_ctr #(.CNT_W(CNT_W)) u_blk_ctr (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (cfg_take),
      .count_in     (cfg_count),
      .block_end    (block_end),
      .remain_after (wb_count),
      .irq          (irq_int)
   );

   assign mem_req     = (state_q == ST_READ) || (state_q == ST_WRITE);
   assign mem_we      = (state_q == ST_WRITE);
   assign mem_addr    = (state_q == ST_WRITE) ? lane_cur[LANE_DST] : lane_cur[LANE_SRC];
   assign busy        = (state_q != ST_IDLE);
   assign irq         = irq_int;
   assign wb_valid    = block_end;
   assign wb_src_addr = lane_wb[LANE_SRC];
   assign wb_src_en   = lane_en[LANE_SRC];
   assign wb_dst_addr = lane_wb[LANE_DST];
   assign wb_dst_en   = lane_en[LANE_DST];
   assign wb_unit_cnt = wb_size;

endmodule

// File: rtl/blkxfer_seq_chk.sv
`timescale 1ns/1ps
module blkxfer_seq_chk #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ack,
   input logic              busy,
   input logic              irq,
   input logic              wb_valid,
   input logic              wb_src_en,
   input logic              wb_dst_en,
   input logic [CNT_W-1:0]  wb_count
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!busy && !mem_req && !irq && !wb_valid));

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R2
   read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && !mem_we) |=> (mem_req && mem_we));

   // R7
   wb_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> ($past(mem_ack) && $past(mem_we) && !mem_req));

   // R7
   wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |=> !wb_valid);

   // R8
   wb_block_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (wb_src_en || wb_dst_en));

   // R9
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(wb_valid) && ($past(wb_count) == '0)));

   // R10
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(start) && !$past(irq)));

   // R10
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |=> !busy);

endmodule

bind blkxfer_seq blkxfer_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_ack   (mem_ack),
   .busy      (busy),
   .irq       (irq),
   .wb_valid  (wb_valid),
   .wb_src_en (wb_src_en),
   .wb_dst_en (wb_dst_en),
   .wb_count  (wb_count)
);

// File: tb/blkxfer_seq_test.sv
`timescale 1ns/1ps
module blkxfer_seq_test;

   localparam int AW = 32;
   localparam int SW = 8;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_load = 1'b0;
   logic [AW-1:0] cfg_src_addr = '0;
   logic [AW-1:0] cfg_dst_addr = '0;
   logic          cfg_src_is_block = 1'b0;
   logic [1:0]    cfg_unit = '0;
   logic [1:0]    cfg_move = '0;
   logic [SW-1:0] cfg_size = '0;
   logic [CW-1:0] cfg_count = '0;
   logic          start = 1'b0;
   logic          mem_req, mem_we, mem_ack = 1'b0;
   logic [AW-1:0] mem_addr;
   logic          busy, irq, wb_valid, wb_src_en, wb_dst_en;
   logic [AW-1:0] wb_src_addr, wb_dst_addr;
   logic [SW-1:0] wb_size, wb_unit_cnt;
   logic [CW-1:0] wb_count;

   always #2.5 clk = ~clk;

   blkxfer_seq #(.ADDR_W(AW), .SIZE_W(SW), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
      .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
      .cfg_src_is_block(cfg_src_is_block), .cfg_unit(cfg_unit),
      .cfg_move(cfg_move), .cfg_size(cfg_size), .cfg_count(cfg_count),
      .start(start), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_ack(mem_ack), .busy(busy), .irq(irq),
      .wb_valid(wb_valid), .wb_src_addr(wb_src_addr), .wb_src_en(wb_src_en),
      .wb_dst_addr(wb_dst_addr), .wb_dst_en(wb_dst_en), .wb_size(wb_size),
      .wb_unit_cnt(wb_unit_cnt), .wb_count(wb_count)
   );

   int checks = 0;
   int failures = 0;

   // scoreboard: expected {we, addr} per request plus its requirement tag
   logic [AW:0] exp_q[$];
   string       tag_q[$];

   // reference model state
   logic [AW-1:0] m_src, m_dst;
   logic          m_sel;
   int            m_step;
   logic [1:0]    m_move;
   int            m_size;
   int            m_cnt;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ack responder and scoreboard monitor
   initial begin
      int gap = 0;
      int seq = 0;
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
         end else if (mem_req) begin
            if (gap > 0) begin
               gap--;
            end else begin
               if (exp_q.size() == 0) begin
                  chk("R2", "unexpected request", {31'd0, mem_we, mem_addr}, 64'hFFFF_FFFF_FFFF_FFFF);
               end else begin
                  logic [AW:0] item;
                  string       t;
                  item = exp_q.pop_front();
                  t    = tag_q.pop_front();
                  chk(t, "request we/addr", {31'd0, mem_we, mem_addr}, {31'd0, item});
               end
               mem_ack = 1'b1;
               seq++;
               gap = seq % 3;
            end
         end
      end
   end

   task automatic configure(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                            input logic sel, input logic [1:0] unit,
                            input logic [1:0] move, input logic [SW-1:0] size,
                            input logic [CW-1:0] count);
      @(negedge clk);
      cfg_src_addr     = src;
      cfg_dst_addr     = dst;
      cfg_src_is_block = sel;
      cfg_unit         = unit;
      cfg_move         = move;
      cfg_size         = size;
      cfg_count        = count;
      cfg_load         = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      m_src  = src;
      m_dst  = dst;
      m_sel  = sel;
      m_step = (unit == 2'd0) ? 1 : (unit == 2'd1) ? 2 : 4;
      m_move = move;
      m_size = (size == '0) ? 256 : int'(size);
      m_cnt  = (count == '0) ? 65536 : int'(count);
   endtask

   // driver: pushes the expected request stream, runs one block, checks write-back
   task automatic run_block(input bit disturb);
      logic [AW-1:0] blk_base, nb;
      logic          nb_en;
      blk_base = m_sel ? m_src : m_dst;
      nb       = m_sel ? m_dst : m_src;
      nb_en    = (m_move == 2'd1) || (m_move == 2'd2);
      for (int k = 0; k < m_size; k++) begin
         logic [AW-1:0] ba;
         ba = blk_base + AW'(k * m_step);
         if (m_sel) begin
            exp_q.push_back({1'b0, ba}); tag_q.push_back("R3 R5 read");
            exp_q.push_back({1'b1, nb}); tag_q.push_back("R4 R5 write");
         end else begin
            exp_q.push_back({1'b0, nb}); tag_q.push_back("R4 R5 read");
            exp_q.push_back({1'b1, ba}); tag_q.push_back("R3 R5 write");
         end
         if (m_move == 2'd1) nb = nb + AW'(m_step);
         else if (m_move == 2'd2) nb = nb - AW'(m_step);
      end
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R10", "busy after start", {63'd0, busy}, 64'd1);
      if (disturb) begin
         @(negedge clk);
         start        = 1'b1;
         cfg_load     = 1'b1;
         cfg_src_addr = 32'hDEAD_0000;
         cfg_dst_addr = 32'hBEEF_0000;
         cfg_size     = 8'd1;
         @(negedge clk);
         start    = 1'b0;
         cfg_load = 1'b0;
      end
      while (!wb_valid) @(negedge clk);
      chk("R6", "requests left in scoreboard", 64'(exp_q.size()), 64'd0);
      chk("R7", "wb src addr", 64'(wb_src_addr), m_sel ? 64'(blk_base) : 64'(nb));
      chk("R7", "wb dst addr", 64'(wb_dst_addr), m_sel ? 64'(nb) : 64'(blk_base));
      chk("R8", "wb src en", {63'd0, wb_src_en}, m_sel ? 64'd1 : {63'd0, nb_en});
      chk("R8", "wb dst en", {63'd0, wb_dst_en}, m_sel ? {63'd0, nb_en} : 64'd1);
      chk("R7", "wb size", 64'(wb_size), 64'(m_size & 8'hFF));
      chk("R7", "wb unit count", 64'(wb_unit_cnt), 64'(m_size & 8'hFF));
      chk("R9", "wb block count", 64'(wb_count), 64'((m_cnt - 1) & 16'hFFFF));
      if (m_sel) m_dst = nb; else m_src = nb;
      m_cnt--;
      @(negedge clk);
      chk("R10", "busy after writeback", {63'd0, busy}, 64'd0);
      chk("R9", "irq after block", {63'd0, irq}, (m_cnt == 0) ? 64'd1 : 64'd0);
      if (disturb) begin
         repeat (3) @(negedge clk);
         chk("R10", "no restart from start seen while busy", {63'd0, busy | mem_req}, 64'd0);
      end
   endtask

   task automatic blocked_start(input string req);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      chk(req, "start ignored", {62'd0, busy, mem_req}, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "reset outputs", {60'd0, busy, mem_req, irq, wb_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "after release", {60'd0, busy, mem_req, irq, wb_valid}, 64'd0);

      // source block area, bytes, destination counts up, two blocks
      configure(32'h0000_1000, 32'h0000_2000, 1'b1, 2'd0, 2'd1, 8'd4, 16'd2);
      run_block(1'b0);
      run_block(1'b0);
      blocked_start("R9");
      chk("R9", "irq held", {63'd0, irq}, 64'd1);

      // destination block area, 2-byte units, source counts down
      configure(32'h0000_0500, 32'h0000_0800, 1'b0, 2'd1, 2'd2, 8'd3, 16'd3);
      chk("R9", "irq cleared by load", {63'd0, irq}, 64'd0);
      run_block(1'b0);
      run_block(1'b1);

      // source block area, 4-byte units, destination held
      configure(32'h0000_4000, 32'h0000_9000, 1'b1, 2'd2, 2'd0, 8'd2, 16'd1);
      run_block(1'b0);

      // destination block area, size 0 and count 0 wrap to maximum
      configure(32'h0000_0100, 32'h0000_7000, 1'b0, 2'd0, 2'd1, 8'd0, 16'd0);
      run_block(1'b0);

      // unit code 3 behaves as 4 bytes, mode 3 holds
      configure(32'h0000_3000, 32'h0000_6000, 1'b0, 2'd3, 2'd3, 8'd2, 16'd1);
      run_block(1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule